// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This block lets an in-order 32-bit core run small loops with no branch instruction and no software counter. It holds two register sets. Each set has a loop start address, a loop end address and an iteration count. The end address names the first word after the loop body, so the last instruction of the body sits at end minus 4. The block watches the address of every instruction that retires. When that address is the last body instruction of an active set, the block decrements the set's count. While iterations remain, it also drives a fetch redirect to the loop start in the same cycle, so the jump back costs no stall.

Set 0 has priority over set 1, which makes set 0 the inner loop of a nested pair. A set is active whenever its count is nonzero. Each set runs a small state machine with three states:
- `LP_IDLE`: count 0.
- `LP_RUN`: count above 1.
- `LP_LAST`: count exactly 1.

The transitions are:
- *load*: a count or setup write moves the set to the state that matches the new count.
- *step*: a decrement from `LP_RUN` goes to `LP_RUN`, or to `LP_LAST` when the count reaches 1.
- *finish*: a decrement from `LP_LAST` goes to `LP_IDLE`.

Software loads the registers through the write port. The port accepts single-field writes or a combined setup that loads all three fields of one set in one cycle. Software reads the registers back through a read-only view, and any attempt to write that view is flagged as illegal. A retiring instruction that is killed, for example by an interrupt taken on it, has no effect. The same instruction counts when it is executed again later.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset every start, end and count reads as 0, and `redir_valid` is 0.
- R2: A write with `wr_kind` 0 (start), 1 (end) or 2 (count) loads only that field of set `wr_set`, visible from the next cycle.
- R3: A write with `wr_kind` 3 (setup) loads start, end and count of set `wr_set` together in one cycle.
- R4: When a retiring, non-killed instruction has address end−4 of an active set whose count is above 1, `redir_valid` is 1 in that same cycle, `redir_pc` equals that set's start, and the count is one lower from the next cycle.
- R5: When such an instruction meets a count of exactly 1, `redir_valid` stays 0 (sequential fetch) and the count becomes 0.
- R6: A set with count 0 never redirects and its count does not change on retirement.
- R7: When both sets match the same retiring instruction, only set 0 redirects or decrements; set 1 is unchanged.
- R8: With `ret_kill` high or `ret_valid` low, no redirect occurs and no count changes.
- R9: The read view maps `view_addr` 0..5 to start0, end0, count0, start1, end1, count1 (set = addr/3, field = addr%3 in start, end, count order), combinationally; other addresses read 0.
- R10: `view_wr` with `view_addr` below 6 raises `view_illegal` in the same cycle and changes no register; other addresses never raise it.
- R11: A count or setup write to a set in the same cycle as that set's decrement takes the written count.
- R12: A retiring address that equals no active set's end−4 causes no redirect and no count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Loop register write strobe |
| wr_set | input | 1 | Target set of the write |
| wr_kind | input | 2 | 0 start, 1 end, 2 count, 3 setup (all three) |
| wr_start | input | 32 | Start address value |
| wr_end | input | 32 | End address value |
| wr_count | input | 32 | Iteration count value |
| ret_valid | input | 1 | An instruction completes this cycle |
| ret_kill | input | 1 | The completing instruction is cancelled (stall, flush, interrupt) |
| ret_pc | input | 32 | Address of the completing instruction |
| view_addr | input | 3 | Read view register index |
| view_wr | input | 1 | Attempted ordinary write to the view |
| view_rdata | output | 32 | Read view data |
| view_illegal | output | 1 | Write attempt targets a loop register |
| redir_valid | output | 1 | Redirect fetch this cycle |
| redir_pc | output | 32 | Redirect target (loop start) |

## Verification
The hardest situation to reach from the ports is an instruction that hits the last body address of both sets at once, or that lands on a decrement cycle in which software also rewrites the count. Random retire addresses alone almost never hit either case. The stimulus therefore draws retire addresses mostly from the current end−4 values of the two sets. It programs both sets with equal or nearby end addresses and small counts, so that overlaps, final iterations and write collisions recur many times. Directed sequences before the random phase pin each of these corners once.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    typedef enum logic [1:0] {
        WK_START = 2'd0,
        WK_END   = 2'd1,
        WK_COUNT = 2'd2,
        WK_SETUP = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        LP_IDLE = 2'd0,
        LP_RUN  = 2'd1,
        LP_LAST = 2'd2
    } lp_state_e;

    localparam int unsigned FIELDS_PER_SET = 3;
    localparam int unsigned INSTR_BYTES    = 4;

endpackage

// File: rtl/hwloop_regset.sv
module hwloop_regset
    import hwloop_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [ADDR_W-1:0] wr_start,
    input  logic [ADDR_W-1:0] wr_end,
    input  logic [CNT_W-1:0]  wr_count,
    input  logic              dec_en,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              active,
    output logic              last_iter
);

    lp_state_e         state_q, state_d;
    logic [CNT_W-1:0]  count_d;
    logic              ld_start, ld_end, ld_count;

    always_comb begin
        ld_start = wr_en && (wr_kind == WK_START || wr_kind == WK_SETUP);
        ld_end   = wr_en && (wr_kind == WK_END   || wr_kind == WK_SETUP);
        ld_count = wr_en && (wr_kind == WK_COUNT || wr_kind == WK_SETUP);
    end

    // Next count and next state
    always_comb begin
        count_d = count_q;
        state_d = state_q;
        if (ld_count) begin
            count_d = wr_count;
            if (wr_count == '0)
                state_d = LP_IDLE;
            else if (wr_count == CNT_W'(1))
                state_d = LP_LAST;
            else
                state_d = LP_RUN;
        end else if (dec_en) begin
            count_d = count_q - CNT_W'(1);
            unique case (state_q)
                LP_RUN:  state_d = (count_q == CNT_W'(2)) ? LP_LAST : LP_RUN;
                LP_LAST: state_d = LP_IDLE;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LP_IDLE;
            count_q <= '0;
            start_q <= '0;
            end_q   <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (ld_start) start_q <= wr_start;
            if (ld_end)   end_q   <= wr_end;
        end
    end

    // Outputs from state
    always_comb begin
        active    = 1'b0;
        last_iter = 1'b0;
        unique case (state_q)
            LP_IDLE: begin active = 1'b0; last_iter = 1'b0; end
            LP_RUN:  begin active = 1'b1; last_iter = 1'b0; end
            LP_LAST: begin active = 1'b1; last_iter = 1'b1; end
            default: begin active = 1'b0; last_iter = 1'b0; end
        endcase
    end

    p_state_tracks_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LP_IDLE) == (count_q == '0));

    p_dec_steps_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !ld_count) |=> (count_q == $past(count_q) - CNT_W'(1)));

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_count |=> (count_q == $past(wr_count)));

    p_no_dec_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> state_q != LP_IDLE);

endmodule

// File: rtl/hwloop_match.sv
module hwloop_match
    import hwloop_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned NUM_LOOPS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ret_valid,
    input  logic                             ret_kill,
    input  logic [ADDR_W-1:0]                ret_pc,
    input  logic [NUM_LOOPS-1:0][ADDR_W-1:0] start_q,
    input  logic [NUM_LOOPS-1:0][ADDR_W-1:0] end_q,
    input  logic [NUM_LOOPS-1:0]             active,
    input  logic [NUM_LOOPS-1:0]             last_iter,
    output logic [NUM_LOOPS-1:0]             dec_en,
    output logic                             redir_valid,
    output logic [ADDR_W-1:0]                redir_pc
);

    logic [NUM_LOOPS-1:0] hit;
    logic                 found;

    always_comb begin
        for (int i = 0; i < NUM_LOOPS; i++) begin
            hit[i] = ret_valid && !ret_kill && active[i] &&
                     (ret_pc == end_q[i] - ADDR_W'(INSTR_BYTES));
        end
    end

    // Lowest index wins: set 0 is the inner loop
    always_comb begin
        dec_en      = '0;
        redir_valid = 1'b0;
        redir_pc    = '0;
        found       = 1'b0;
        for (int i = 0; i < NUM_LOOPS; i++) begin
            if (hit[i] && !found) begin
                found       = 1'b1;
                dec_en[i]   = 1'b1;
                redir_valid = !last_iter[i];
                redir_pc    = start_q[i];
            end
        end
    end

    p_single_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_en));

    p_redirect_needs_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (ret_valid && !ret_kill));

    p_redirect_implies_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (dec_en != '0));

endmodule

// File: rtl/hwloop_view.sv
module hwloop_view
    import hwloop_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned NUM_LOOPS = 2,
    parameter int unsigned VIEW_AW   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [VIEW_AW-1:0]               view_addr,
    input  logic                             view_wr,
    input  logic [NUM_LOOPS-1:0][ADDR_W-1:0] start_q,
    input  logic [NUM_LOOPS-1:0][ADDR_W-1:0] end_q,
    input  logic [NUM_LOOPS-1:0][CNT_W-1:0]  count_q,
    output logic [ADDR_W-1:0]                view_rdata,
    output logic                             view_illegal
);

    localparam int unsigned NUM_REGS = FIELDS_PER_SET * NUM_LOOPS;

    logic in_range;

    always_comb begin
        in_range   = 32'(view_addr) < NUM_REGS;
        view_rdata = '0;
        for (int i = 0; i < NUM_LOOPS; i++) begin
            if (32'(view_addr) == FIELDS_PER_SET * i)
                view_rdata = start_q[i];
            if (32'(view_addr) == FIELDS_PER_SET * i + 1)
                view_rdata = end_q[i];
            if (32'(view_addr) == FIELDS_PER_SET * i + 2)
                view_rdata = ADDR_W'(count_q[i]);
        end
        view_illegal = view_wr && in_range;
    end

    p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (view_wr && 32'(view_addr) < NUM_REGS) |-> view_illegal);

    p_legal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !view_wr |-> !view_illegal);

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned NUM_LOOPS = 2,
    parameter int unsigned VIEW_AW   = 3,
    parameter int unsigned SET_W     = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SET_W-1:0]   wr_set,
    input  logic [1:0]         wr_kind,
    input  logic [ADDR_W-1:0]  wr_start,
    input  logic [ADDR_W-1:0]  wr_end,
    input  logic [CNT_W-1:0]   wr_count,
    input  logic               ret_valid,
    input  logic               ret_kill,
    input  logic [ADDR_W-1:0]  ret_pc,
    input  logic [VIEW_AW-1:0] view_addr,
    input  logic               view_wr,
    output logic [ADDR_W-1:0]  view_rdata,
    output logic               view_illegal,
    output logic               redir_valid,
    output logic [ADDR_W-1:0]  redir_pc
);

    logic [NUM_LOOPS-1:0][ADDR_W-1:0] start_q;
    logic [NUM_LOOPS-1:0][ADDR_W-1:0] end_q;
    logic [NUM_LOOPS-1:0][CNT_W-1:0]  count_q;
    logic [NUM_LOOPS-1:0]             active;
    logic [NUM_LOOPS-1:0]             last_iter;
    logic [NUM_LOOPS-1:0]             dec_en;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_set
        hwloop_regset #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_set (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en && (32'(wr_set) == g)),
            .wr_kind   (wr_kind),
            .wr_start  (wr_start),
            .wr_end    (wr_end),
            .wr_count  (wr_count),
            .dec_en    (dec_en[g]),
            .start_q   (start_q[g]),
            .end_q     (end_q[g]),
            .count_q   (count_q[g]),
            .active    (active[g]),
            .last_iter (last_iter[g])
        );
    end

    hwloop_match #(.ADDR_W(ADDR_W), .NUM_LOOPS(NUM_LOOPS)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .ret_valid   (ret_valid),
        .ret_kill    (ret_kill),
        .ret_pc      (ret_pc),
        .start_q     (start_q),
        .end_q       (end_q),
        .active      (active),
        .last_iter   (last_iter),
        .dec_en      (dec_en),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc)
    );

    hwloop_view #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_LOOPS(NUM_LOOPS),
                  .VIEW_AW(VIEW_AW)) u_view (
        .clk          (clk),
        .rst_n        (rst_n),
        .view_addr    (view_addr),
        .view_wr      (view_wr),
        .start_q      (start_q),
        .end_q        (end_q),
        .count_q      (count_q),
        .view_rdata   (view_rdata),
        .view_illegal (view_illegal)
    );

    p_kill_holds_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_kill && !wr_en) |=> (count_q == $past(count_q)));

    p_redirect_to_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && dec_en[0]) |-> (redir_pc == start_q[0]));

endmodule

// File: tb/hwloop_ctrl_tb.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [0:0]  wr_set;
    logic [1:0]  wr_kind;
    logic [31:0] wr_start, wr_end, wr_count;
    logic        ret_valid, ret_kill;
    logic [31:0] ret_pc;
    logic [2:0]  view_addr;
    logic        view_wr;
    logic [31:0] view_rdata;
    logic        view_illegal;
    logic        redir_valid;
    logic [31:0] redir_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] ms [2];
    logic [31:0] me [2];
    logic [31:0] mc [2];

    always #2.5 clk = ~clk;

    hwloop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set), .wr_kind(wr_kind),
        .wr_start(wr_start), .wr_end(wr_end), .wr_count(wr_count),
        .ret_valid(ret_valid), .ret_kill(ret_kill), .ret_pc(ret_pc),
        .view_addr(view_addr), .view_wr(view_wr), .view_rdata(view_rdata),
        .view_illegal(view_illegal), .redir_valid(redir_valid), .redir_pc(redir_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_view(input logic [2:0] a);
        case (a)
            3'd0: return ms[0];
            3'd1: return me[0];
            3'd2: return mc[0];
            3'd3: return ms[1];
            3'd4: return me[1];
            3'd5: return mc[1];
            default: return 32'h0;
        endcase
    endfunction

    task automatic idle_inputs();
        wr_en = 0; wr_set = 0; wr_kind = 0; wr_start = 0; wr_end = 0; wr_count = 0;
        ret_valid = 0; ret_kill = 0; ret_pc = 32'hFFFF_FFF0; view_addr = 0; view_wr = 0;
    endtask

    // Inputs are set just after a falling edge; check, clock, update model.
    task automatic step(input string req);
        int   hit;
        logic ev;
        logic [31:0] ep;
        #1;
        hit = -1;
        for (int i = 1; i >= 0; i--)
            if (ret_valid && !ret_kill && mc[i] != 0 && ret_pc == me[i] - 32'd4) hit = i;
        ev = (hit >= 0) && (mc[hit] > 1);
        ep = ev ? ms[hit] : redir_pc;
        chk({req, " redir_valid"}, {31'b0, redir_valid}, {31'b0, ev});
        if (ev) chk({req, " R4 redir_pc"}, redir_pc, ep);
        chk({req, " R9 view_rdata"}, view_rdata, exp_view(view_addr));
        chk({req, " R10 view_illegal"}, {31'b0, view_illegal},
            {31'b0, view_wr && view_addr < 3'd6});
        @(posedge clk);
        if (hit >= 0) mc[hit] = mc[hit] - 1;
        if (wr_en) begin
            if (wr_kind == 2'd0 || wr_kind == 2'd3) ms[wr_set] = wr_start;
            if (wr_kind == 2'd1 || wr_kind == 2'd3) me[wr_set] = wr_end;
            if (wr_kind == 2'd2 || wr_kind == 2'd3) mc[wr_set] = wr_count;
        end
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic setup(input int s, input logic [31:0] st, input logic [31:0] en,
                         input logic [31:0] ct, input string req);
        wr_en = 1; wr_set = 1'(s); wr_kind = 2'd3; wr_start = st; wr_end = en; wr_count = ct;
        step(req);
    endtask

    task automatic retire(input logic [31:0] pc, input logic kill, input string req);
        ret_valid = 1; ret_kill = kill; ret_pc = pc;
        step(req);
    endtask

    task automatic view_all(input string req);
        for (int a = 0; a < 8; a++) begin
            view_addr = 3'(a);
            step(req);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin ms[i] = 0; me[i] = 0; mc[i] = 0; end
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 redir_valid", {31'b0, redir_valid}, 32'd0);
        view_all("R1");

        // R2: single-field writes, one at a time
        wr_en = 1; wr_set = 1; wr_kind = 2'd0; wr_start = 32'h200; step("R2 start");
        wr_en = 1; wr_set = 1; wr_kind = 2'd1; wr_end = 32'h240; step("R2 end");
        wr_en = 1; wr_set = 1; wr_kind = 2'd2; wr_count = 32'd2; step("R2 count");
        view_all("R2");

        // R3 + R4 + R5: setup, two redirects then a fall-through
        setup(0, 32'h100, 32'h10C, 32'd3, "R3");
        view_all("R3");
        retire(32'h108, 0, "R4 iter1");
        retire(32'h108, 0, "R4 iter2");
        view_addr = 3'd2; retire(32'h108, 0, "R5 last");
        view_addr = 3'd2; step("R5 count zero");
        // R6: set 0 now idle
        retire(32'h108, 0, "R6 idle");
        view_addr = 3'd2; step("R6 count");

        // R8: kill and no-valid block everything
        setup(0, 32'h100, 32'h10C, 32'd4, "R8 setup");
        retire(32'h108, 1, "R8 kill");
        ret_valid = 0; ret_pc = 32'h108; step("R8 novalid");
        view_addr = 3'd2; step("R8 count held");

        // R12: non-matching address
        retire(32'h104, 0, "R12 miss");
        view_addr = 3'd2; step("R12 count");

        // R7: both sets end at the same place
        setup(1, 32'h0F0, 32'h10C, 32'd5, "R7 setup");
        retire(32'h108, 0, "R7 both");
        view_addr = 3'd5; step("R7 set1 held");
        view_addr = 3'd2; step("R7 set0 dec");

        // R11: write collides with a decrement
        ret_valid = 1; ret_pc = 32'h108;
        wr_en = 1; wr_set = 0; wr_kind = 2'd2; wr_count = 32'd9; step("R11 collide");
        view_addr = 3'd2; step("R11 count");

        // R10: illegal write attempts leave registers intact
        for (int a = 0; a < 8; a++) begin
            view_wr = 1; view_addr = 3'(a); step("R10 wr attempt");
        end
        view_all("R10 after");

        // Random phase, retire addresses biased toward loop ends
        void'($urandom(32'd12345));
        for (int n = 0; n < 6000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 8) begin
                int s;
                s = $urandom_range(0, 1);
                wr_en = 1; wr_set = 1'(s); wr_kind = 2'($urandom_range(0, 3));
                wr_start = 32'h100 + 32'($urandom_range(0, 3)) * 4;
                wr_end   = 32'h110 + 32'($urandom_range(0, 3)) * 4;
                wr_count = 32'($urandom_range(0, 4));
            end
            if (r >= 5) begin
                int p;
                p = $urandom_range(0, 9);
                ret_valid = ($urandom_range(0, 7) != 0);
                ret_kill  = ($urandom_range(0, 7) == 0);
                if (p < 4)      ret_pc = me[0] - 32'd4;
                else if (p < 8) ret_pc = me[1] - 32'd4;
                else            ret_pc = 32'h100 + 32'($urandom_range(0, 15)) * 4;
            end
            view_addr = 3'($urandom_range(0, 7));
            view_wr   = ($urandom_range(0, 15) == 0);
            step("R12 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule